// File: doc/BRIEF.md
# Digital FLL lock controller

This block closes a frequency-locked loop around a digitally trimmed high-frequency oscillator. Once per cycle of a 32.768 kHz reference it counts the oscillator cycles that fell inside the period. It then steers a 10-bit trim word so that this count matches a programmed divide ratio. The oscillator edges and the reference period boundary reach the block as single-cycle pulses in its own clock domain.

A single 8-bit configuration register controls the loop. It holds the loop enable, two lock requests, a spread-spectrum enable and a spread-bandwidth selector. A lock request starts a successive-approximation search. A coarse request searches the whole trim word and can move the oscillator a long way. A fine request searches only the low 4-bit bank, so the frequency moves only slightly. When the search finishes, the request bit clears itself, a done strobe pulses, and the loop falls back to tracking one LSB at a time.

The loop enable is set by hardware on the first rising edge of a crystal-stable input. Software may clear or set it later. An external write-protect input blocks register writes.

Top module: `fll_lock_ctrl`

## Requirements
- R1: The configuration register resets to 0x00. It uses these bit positions: bit0 loop enable, bit1 coarse request, bit2 fine request, bits6:5 bandwidth select, bit7 spread enable. Bits 4:3 always read 0. A write with `cfg_wp` low is visible on `cfg_q` one cycle later.
- R2: While `cfg_wp` is high, a register write has no effect on `cfg_q`.
- R3: Bit0 stays 0 while `xtal_ok` is low. It is set one cycle after `xtal_ok` rises. A later software write of 0 keeps it at 0 even while `xtal_ok` stays high.
- R4: The trim word resets to 512. While bit0 is 0, `trim` holds its value and `tracking` is 0.
- R5: `ss_en` equals bit7. `ss_bw_khz` reads 16, 32, 64 and 128 for bandwidth select 00, 01, 10 and 11.
- R6: A coarse search tests trim bits 9 down to 0, one per reference period. It clears the tested bit when the count exceeds `div_ratio`. The result is the largest trim whose count does not exceed the ratio.
- R7: A fine search tests only trim bits 3 down to 0 and leaves bits 9:4 unchanged.
- R8: At the end of a search, the request bit reads 0, `lock_done` is high for exactly one cycle, and `tracking` is 1.
- R9: When both requests are set together, the coarse search runs, and both request bits clear when it completes.
- R10: In tracking, each reference period moves `trim` by at most one. It rises when count+1 < ratio and falls when count > ratio+1. Otherwise it is left alone.
- R11: Tracking saturates `trim` at 0 and at 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write data |
| cfg_wp | input | 1 | Write protect; blocks writes |
| xtal_ok | input | 1 | Crystal oscillator stable |
| div_ratio | input | 12 | Target oscillator cycles per reference period |
| osc_pulse | input | 1 | One pulse per oscillator cycle |
| ref_tick | input | 1 | Last cycle of each reference period |
| cfg_q | output | 8 | Configuration register contents |
| trim | output | 10 | Oscillator trim word |
| tracking | output | 1 | Loop is in continuous tracking |
| lock_done | output | 1 | One-cycle strobe at the end of a search |
| ss_en | output | 1 | Spread spectrum enabled |
| ss_bw_khz | output | 8 | Selected spreading bandwidth in kHz |

## Verification
The hardest situation to reach is a fine search whose best answer lies outside the current upper bank. Only then does the difference between the low-bank search and a full search show at the pins. The bench first coarse-locks to one ratio. It then raises the ratio far enough that the ideal trim needs a carry into bit 4, and requests a fine lock. The fine search must pin the low bank at 15 and leave bits 9:4 untouched. A later run with both requests set must instead reach the exact full-word answer.

// File: rtl/fll_lock_ctrl.sv
module fll_lock_ctrl #(
  parameter int TW       = 10,
  parameter int FW       = 4,
  parameter int CW       = 12,
  parameter int TRIM_RST = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [7:0]    cfg_wr_data,
  input  logic          cfg_wp,
  input  logic          xtal_ok,
  input  logic [CW-1:0] div_ratio,
  input  logic          osc_pulse,
  input  logic          ref_tick,
  output logic [7:0]    cfg_q,
  output logic [TW-1:0] trim,
  output logic          tracking,
  output logic          lock_done,
  output logic          ss_en,
  output logic [7:0]    ss_bw_khz
);
  localparam int BW = $clog2(TW);
  localparam logic [7:0] CFG_MASK = 8'hE7;
  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [CW+1:0] ONE2 = {{(CW+1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_SRCH, S_TRK} st_t;

  st_t             st;
  logic [7:0]      cfg;
  logic [7:0]      cfg_nx;
  logic            xtal_q;
  logic            fine_run;
  logic [BW-1:0]   bit_idx;
  logic [CW-1:0]   cnt;
  logic            valid;
  logic            done_q;

  logic [CW:0]     meas;
  logic [CW+1:0]   m2, d2;
  logic            over, over_db, under_db, eval, sar_done;
  logic            en, xtal_rise, wr_ok;

  assign en        = cfg[0];
  assign xtal_rise = xtal_ok & ~xtal_q;
  assign wr_ok     = cfg_wr_en & ~cfg_wp;

  assign meas     = {1'b0, cnt} + {{CW{1'b0}}, osc_pulse};
  assign m2       = {1'b0, meas};
  assign d2       = {2'b00, div_ratio};
  assign over     = m2 > d2;
  assign over_db  = m2 > d2 + ONE2;
  assign under_db = m2 + ONE2 < d2;
  assign eval     = ref_tick & valid;
  assign sar_done = en & (st == S_SRCH) & eval & (bit_idx == '0);

  always_comb begin
    cfg_nx = cfg;
    if (xtal_rise) cfg_nx[0] = 1'b1;
    if (sar_done) begin
      cfg_nx[2] = 1'b0;
      if (!fine_run) cfg_nx[1] = 1'b0;
    end
    if (wr_ok) cfg_nx = cfg_wr_data & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      xtal_q <= 1'b0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      cfg    <= cfg_nx;
      xtal_q <= xtal_ok;
      done_q <= sar_done;
      if (ref_tick)                 cnt <= '0;
      else if (osc_pulse && cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      trim     <= TW'(TRIM_RST);
      fine_run <= 1'b0;
      bit_idx  <= '0;
      valid    <= 1'b0;
    end else if (!en) begin
      st    <= S_IDLE;
      valid <= 1'b0;
    end else begin
      case (st)
        S_SRCH: begin
          if (ref_tick) valid <= 1'b1;
          if (eval) begin
            if (over) trim[bit_idx] <= 1'b0;
            if (bit_idx == '0) begin
              st <= S_TRK;
            end else begin
              trim[bit_idx - 1'b1] <= 1'b1;
              bit_idx <= bit_idx - 1'b1;
            end
          end
        end
        default: begin
          if (cfg[1] || cfg[2]) begin
            st    <= S_SRCH;
            valid <= 1'b0;
            if (cfg[1]) begin
              fine_run <= 1'b0;
              bit_idx  <= BW'(TW-1);
              trim     <= {1'b1, {(TW-1){1'b0}}};
            end else begin
              fine_run <= 1'b1;
              bit_idx  <= BW'(FW-1);
              trim[FW-1:0] <= {1'b1, {(FW-1){1'b0}}};
            end
          end else if (st == S_IDLE) begin
            st    <= S_TRK;
            valid <= 1'b0;
          end else begin
            if (ref_tick) valid <= 1'b1;
            if (eval) begin
              if (over_db && trim != '0)        trim <= trim - 1'b1;
              else if (under_db && trim != TMAX) trim <= trim + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign cfg_q     = cfg;
  assign tracking  = en & (st == S_TRK);
  assign lock_done = done_q;
  assign ss_en     = cfg[7];
  assign ss_bw_khz = 8'd16 << cfg[6:5];
endmodule

// File: rtl/fll_lock_ctrl_chk.sv
module fll_lock_ctrl_chk #(
  parameter int TW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr_en,
  input logic [7:0]    cfg_wr_data,
  input logic          cfg_wp,
  input logic [7:0]    cfg_q,
  input logic [TW-1:0] trim,
  input logic          tracking,
  input logic          lock_done
);
  // R1
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && !cfg_wp |=> cfg_q == ($past(cfg_wr_data) & 8'hE7));

  // R2
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wp |=> cfg_q[7:5] == $past(cfg_q[7:5]));

  // R4
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[0] |=> trim == $past(trim));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |=> !lock_done);

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done && !$past(cfg_wr_en) |-> !cfg_q[1] && tracking);

  // R10
  trk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tracking && $past(tracking) |->
      (trim == $past(trim)) || (trim == $past(trim) + 1'b1) || (trim == $past(trim) - 1'b1));
endmodule

bind fll_lock_ctrl fll_lock_ctrl_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .cfg_wp(cfg_wp), .cfg_q(cfg_q), .trim(trim), .tracking(tracking),
  .lock_done(lock_done)
);

// File: tb/sim_fll_lock_ctrl.sv
module sim_fll_lock_ctrl;
  localparam int OFS = 200;
  localparam int PER = 1250;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr_en = 0;
  logic [7:0]  cfg_wr_data = 0;
  logic        cfg_wp = 0;
  logic        xtal_ok = 0;
  logic [11:0] div_ratio = 12'd712;
  logic        osc_pulse = 0;
  logic        ref_tick = 0;
  logic [7:0]  cfg_q;
  logic [9:0]  trim;
  logic        tracking, lock_done, ss_en;
  logic [7:0]  ss_bw_khz;

  int nvec = 0;
  int nbad = 0;
  int cyc  = 0;

  fll_lock_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_wp(cfg_wp), .xtal_ok(xtal_ok), .div_ratio(div_ratio),
    .osc_pulse(osc_pulse), .ref_tick(ref_tick), .cfg_q(cfg_q), .trim(trim),
    .tracking(tracking), .lock_done(lock_done), .ss_en(ss_en), .ss_bw_khz(ss_bw_khz)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      nbad = nbad + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  // behavioural oscillator: count = OFS + trim per reference period
  initial begin
    @(posedge rst_n);
    forever begin
      int n;
      n = OFS + int'(trim);
      for (int i = 0; i < PER; i++) begin
        osc_pulse = (i < n);
        ref_tick  = (i == PER-1);
        @(negedge clk);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (ref_tick) k++;
    end
    @(negedge clk);
  endtask

  task automatic wait_lock(input string req, input int exp_trim);
    int t = 0;
    while (!lock_done && t < 15*PER) begin
      @(negedge clk);
      t++;
    end
    check({req, " lock_done seen"}, int'(lock_done), 1);
    check({req, " trim"}, int'(trim), exp_trim);
    check("R8 tracking after lock", int'(tracking), 1);
    @(negedge clk);
    check("R8 lock_done one cycle", int'(lock_done), 0);
  endtask

  task automatic t_reset;
    check("R1 cfg reset", int'(cfg_q), 0);
    check("R4 trim reset", int'(trim), 512);
    check("R4 tracking reset", int'(tracking), 0);
    check("R8 lock_done reset", int'(lock_done), 0);
    check("R5 ss_en reset", int'(ss_en), 0);
    check("R5 bw reset", int'(ss_bw_khz), 16);
  endtask

  task automatic t_cfg;
    repeat (100) @(negedge clk);
    check("R3 enable low without crystal", int'(cfg_q[0]), 0);
    xtal_ok = 1;
    @(negedge clk); @(negedge clk);
    check("R3 auto enable", int'(cfg_q[0]), 1);
    cfg_wp = 1;
    wr(8'hE0);
    @(negedge clk);
    check("R2 write protected", int'(cfg_q), 8'h01);
    cfg_wp = 0;
    wr(8'hF8);
    check("R1 write reserved masked", int'(cfg_q), 8'hE0);
    repeat (50) @(negedge clk);
    check("R3 software clear sticks", int'(cfg_q[0]), 0);
    check("R5 ss_en", int'(ss_en), 1);
    check("R5 bw sel 11", int'(ss_bw_khz), 128);
    wr(8'h20);
    check("R5 bw sel 01", int'(ss_bw_khz), 32);
    wr(8'h40);
    check("R5 bw sel 10", int'(ss_bw_khz), 64);
    check("R4 trim held", int'(trim), 512);
  endtask

  task automatic t_coarse(input int tgt, input int exp);
    @(negedge clk); div_ratio = 12'(tgt);
    wr(8'h03);
    wait_lock("R6 coarse", exp);
    check("R8 coarse request cleared", int'(cfg_q[1]), 0);
  endtask

  task automatic t_fine;
    @(negedge clk); div_ratio = 12'd720;
    wr(8'h05);
    wait_lock("R7 fine", 511);
    check("R7 upper bank kept", int'(trim[9:4]), 31);
    check("R8 fine request cleared", int'(cfg_q[2]), 0);
  endtask

  task automatic t_prio;
    @(negedge clk); div_ratio = 12'd900;
    wr(8'h07);
    wait_lock("R9 coarse priority", 700);
    check("R9 both requests cleared", int'(cfg_q[2:1]), 0);
  endtask

  task automatic t_track;
    @(negedge clk); div_ratio = 12'd905;
    wait_ticks(6);
    check("R10 track up", int'(trim), 704);
    wait_ticks(2);
    check("R10 deadband hold", int'(trim), 704);
    @(negedge clk); div_ratio = 12'd895;
    wait_ticks(10);
    check("R10 track down", int'(trim), 696);
  endtask

  task automatic t_disable;
    wr(8'h00);
    @(negedge clk); div_ratio = 12'd1000;
    wait_ticks(3);
    check("R4 trim held when disabled", int'(trim), 696);
    check("R4 not tracking", int'(tracking), 0);
  endtask

  task automatic t_sat;
    t_coarse(1500, 1023);
    wait_ticks(3);
    check("R11 saturate high", int'(trim), 1023);
    t_coarse(100, 0);
    wait_ticks(3);
    check("R11 saturate low", int'(trim), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_cfg();
    t_coarse(700, 500);
    t_fine();
    t_prio();
    t_track();
    t_disable();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule